// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block gathers interrupt requests from two kinds of source into one 32-bit vector word and a single interrupt line. Peripheral requests are level-style: a vector stays pending only while its request input is held high. GPIO requests are edge-style: each pin is synchronised, checked for a rising and/or falling transition, and a transition is caught in a sticky per-pin status bit that software clears by writing a one.

The low eleven GPIO pins each own a vector. The remaining pins share one lumped vector, which is the OR of their status bits. Masking is done per vector, so every pin on the lumped vector is enabled or blocked together, while edge status stays per pin. There is no priority: every unmasked pending vector is ORed onto the interrupt line. Software reaches the configuration through a small word-addressed register port with a combinational read path.

Top module: `gei_ctrl`

## Requirements
- R1: After reset the rising-enable, falling-enable, edge-status and vector-enable registers read zero, `pend_vec` is zero and `irq` is low.
- R2: A GPIO pin change driven before a clock edge is seen by a two-flop synchroniser. Its status bit reads set after the third rising clock edge that follows the change, and still reads clear after the second.
- R3: Register 0 enables rising-edge detection per pin (bit n = pin n) and register 1 enables falling-edge detection. With only one enabled, the other direction leaves the status bit clear. With both enabled, either direction sets it. With neither enabled, the pin never sets its status bit.
- R4: Register 2 holds edge status. A status bit stays set until a write to register 2 carries a one in that bit position. Zero bits in the written word leave the matching status bits unchanged.
- R5: When a new edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: Vector v (v = 0 to 10) is the status bit of GPIO pin v. Vector 11 is the OR of the status bits of pins 11 to 31, and it stays pending as long as any of those bits is set.
- R7: Vector 12+k is peripheral request input k (k = 0 to 19). It is not latched, follows the input in the same cycle, and drops as soon as the input drops.
- R8: Register 3 enables vectors (bit v = 1 lets vector v through). `pend_vec` equals the raw vector word ANDed with register 3, and `irq` is the OR of `pend_vec`. Clearing bit 11 blocks all pins 11 to 31 together and leaves their status bits unchanged.
- R9: Register 4 reads `pend_vec` and ignores writes. Addresses 5 to 7 read zero.
- R10: There is no priority. Several unmasked pending vectors show up in `pend_vec` at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | GPIO_W | Asynchronous GPIO pin levels |
| periph_req | input | DATA_W-DED_N-1 | Level-style peripheral requests |
| reg_wr | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| pend_vec | output | DATA_W | Masked pending vector word |
| irq | output | 1 | Interrupt request, OR of pend_vec |

## Verification
A GPIO change is driven on a falling clock edge, and its status bit is due after the third rising edge: two synchroniser stages, then the status capture. The bench reads once after the second edge, when the bit must still be clear, and again after the third. A peripheral request and a mask bit reach `pend_vec` and `irq` combinationally, and register writes take effect at the next rising edge. So every read and output sample is taken one time unit after a falling edge, once the edge that the requirement names has gone by. For the collision case, the clearing write is timed to land on the rising edge that captures the new edge.

// File: rtl/gei_pkg.sv
package gei_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RISE = 3'd0,
        REG_FALL = 3'd1,
        REG_STAT = 3'd2,
        REG_MASK = 3'd3,
        REG_PEND = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/gei_sync_edge.sv
module gei_sync_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] edge_hit_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign edge_hit_o[i] = (rise_en_i[i] &  st_q.s2[i] & ~st_q.s3[i])
                             | (fall_en_i[i] & ~st_q.s2[i] &  st_q.s3[i]);
    end

    // R3: a pin with both detectors off never reports an edge
    a_r3_disabled_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit_o & ~(rise_en_i | fall_en_i)) == '0));
endmodule

// File: rtl/gei_edge_status.sv
module gei_edge_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] edge_hit_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | edge_hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.flags;

    // R4: a set bit survives every cycle without a clearing one
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(stat_o) & ~$past(clr_i))) & ~stat_o) == '0));

    // R5: an edge in the clearing cycle keeps the bit set
    a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(edge_hit_i) & $past(clr_i)) & ~stat_o) == '0));

    // R2: a status bit becomes set only from a detected edge
    a_r2_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat_o & ~$past(stat_o)) & ~$past(edge_hit_i)) == '0));
endmodule

// File: rtl/gei_vec_map.sv
module gei_vec_map #(
    parameter int GPIO_W = 32,
    parameter int DED_N  = 11,
    parameter int VEC_W  = 32,
    parameter int PER_N  = VEC_W - DED_N - 1
) (
    input  logic [GPIO_W-1:0] stat_i,
    input  logic [PER_N-1:0]  periph_i,
    input  logic [VEC_W-1:0]  mask_i,
    output logic [VEC_W-1:0]  pend_o,
    output logic              irq_o
);
    localparam int LUMP_V = DED_N;
    localparam int PER_LO = DED_N + 1;

    logic [VEC_W-1:0] raw;

    for (genvar v = 0; v < DED_N; v++) begin : g_ded
        assign raw[v] = stat_i[v];
    end

    assign raw[LUMP_V] = |stat_i[GPIO_W-1:DED_N];

    for (genvar k = 0; k < PER_N; k++) begin : g_per
        assign raw[PER_LO+k] = periph_i[k];
    end

    assign pend_o = raw & mask_i;
    assign irq_o  = |pend_o;
endmodule

// File: rtl/gei_ctrl.sv
module gei_ctrl
    import gei_pkg::*;
#(
    parameter int GPIO_W = 32,
    parameter int DED_N  = 11,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [GPIO_W-1:0]         gpio_in,
    input  logic [DATA_W-DED_N-2:0]   periph_req,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [DATA_W-1:0]         pend_vec,
    output logic                      irq
);
    localparam int PER_N  = DATA_W - DED_N - 1;
    localparam int LUMP_V = DED_N;

    typedef struct packed {
        logic [GPIO_W-1:0] rise_en;
        logic [GPIO_W-1:0] fall_en;
        logic [DATA_W-1:0] vec_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [GPIO_W-1:0] edge_hit;
    logic [GPIO_W-1:0] clr_mask;
    logic [GPIO_W-1:0] stat;

    always_comb begin
        cfg_d    = cfg_q;
        clr_mask = '0;
        if (reg_wr) begin
            case (reg_addr)
                REG_RISE: cfg_d.rise_en = reg_wdata[GPIO_W-1:0];
                REG_FALL: cfg_d.fall_en = reg_wdata[GPIO_W-1:0];
                REG_STAT: clr_mask      = reg_wdata[GPIO_W-1:0];
                REG_MASK: cfg_d.vec_en  = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    gei_sync_edge #(.W(GPIO_W)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (gpio_in),
        .rise_en_i  (cfg_q.rise_en),
        .fall_en_i  (cfg_q.fall_en),
        .edge_hit_o (edge_hit)
    );

    gei_edge_status #(.W(GPIO_W)) i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_hit_i (edge_hit),
        .clr_i      (clr_mask),
        .stat_o     (stat)
    );

    gei_vec_map #(
        .GPIO_W (GPIO_W),
        .DED_N  (DED_N),
        .VEC_W  (DATA_W),
        .PER_N  (PER_N)
    ) i_map (
        .stat_i   (stat),
        .periph_i (periph_req),
        .mask_i   (cfg_q.vec_en),
        .pend_o   (pend_vec),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_RISE: reg_rdata = DATA_W'(cfg_q.rise_en);
            REG_FALL: reg_rdata = DATA_W'(cfg_q.fall_en);
            REG_STAT: reg_rdata = DATA_W'(stat);
            REG_MASK: reg_rdata = cfg_q.vec_en;
            REG_PEND: reg_rdata = pend_vec;
            default:  reg_rdata = '0;
        endcase
    end

    // R8: nothing passes a cleared vector-enable bit
    a_r8_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & ~cfg_q.vec_en) == '0));

    // R8: the interrupt line rises only with some pending vector
    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_vec != '0));

    // R6: the lumped vector needs a set status bit among the shared pins
    a_r6_lump_backed: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec[LUMP_V] |-> (|stat[GPIO_W-1:DED_N]));

    // R9: a write to the pending address leaves configuration unchanged
    a_r9_pend_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_PEND) |=> $stable(cfg_q));
endmodule

// File: tb/test_gei_ctrl.sv
`timescale 1ns/1ps
module test_gei_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] gpio_in = '0;
    logic [19:0] periph_req = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pend_vec;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gei_ctrl i_gei_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .gpio_in    (gpio_in),
        .periph_req (periph_req),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pend_vec   (pend_vec),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        gpio_in    = '0;
        periph_req = '0;
        reg_wr     = 1'b0;
        rst_n      = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pins(input logic [31:0] v);
        gpio_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg %0d after reset", a), v, 32'h0);
        end
        chk("R1 pend_vec after reset", pend_vec, 32'h0);
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0008);
        wr(3'd3, 32'hFFFF_FFFF);
        gpio_in = 32'h0000_0008;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd2, v);
        chk("R2 status clear after two edges", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(3'd2, v);
        chk("R2 status set after third edge", v, 32'h0000_0008);
        chk("R8 irq from pin 3", {31'h0, irq}, 32'h1);
        chk("R6 pin 3 on vector 3", pend_vec, 32'h0000_0008);
    endtask

    task automatic t_modes();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0088);
        wr(3'd1, 32'h0000_00A0);
        pins(32'h0000_0120);
        rd(3'd2, v);
        chk("R3 falling-only pin 5 ignores rise, rise-only untouched", v, 32'h0);
        pins(32'h0000_0000);
        rd(3'd2, v);
        chk("R3 falling-only pin 5 catches fall", v, 32'h0000_0020);
        wr(3'd2, 32'hFFFF_FFFF);
        pins(32'h0000_0080);
        rd(3'd2, v);
        chk("R3 both-edge pin 7 catches rise", v, 32'h0000_0080);
        wr(3'd2, 32'h0000_0080);
        pins(32'h0000_0000);
        rd(3'd2, v);
        chk("R3 both-edge pin 7 catches fall", v, 32'h0000_0080);
        wr(3'd2, 32'h0000_0080);
        pins(32'h0000_0108);
        wr(3'd2, 32'h0000_0008);
        pins(32'h0000_0000);
        rd(3'd2, v);
        chk("R3 rise-only pin 3 ignores fall, pin 8 disabled", v, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0028);
        pins(32'h0000_0028);
        rd(3'd2, v);
        chk("R4 two bits set", v, 32'h0000_0028);
        wr(3'd2, 32'h0000_0000);
        rd(3'd2, v);
        chk("R4 zero write leaves bits", v, 32'h0000_0028);
        wr(3'd2, 32'h0000_0008);
        rd(3'd2, v);
        chk("R4 one clears only its bit", v, 32'h0000_0020);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0200);
        wr(3'd1, 32'h0000_0200);
        pins(32'h0000_0200);
        gpio_in = 32'h0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        reg_addr  = 3'd2;
        reg_wdata = 32'h0000_0200;
        reg_wr    = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd2, v);
        chk("R5 edge beats clear in same cycle", v, 32'h0000_0200);
        wr(3'd2, 32'h0000_0200);
        rd(3'd2, v);
        chk("R4 plain clear afterwards", v, 32'h0);
    endtask

    task automatic t_lump();
        logic [31:0] v;
        wr(3'd0, 32'h8010_0000);
        wr(3'd3, 32'h0000_0800);
        pins(32'h8010_0000);
        chk("R6 pins 20 and 31 on lumped vector 11", pend_vec, 32'h0000_0800);
        wr(3'd2, 32'h0010_0000);
        chk("R6 lumped vector held by pin 31", pend_vec, 32'h0000_0800);
        wr(3'd3, 32'h0000_0000);
        chk("R8 lumped vector masked", {31'h0, irq}, 32'h0);
        rd(3'd2, v);
        chk("R8 masking keeps per-pin status", v, 32'h8000_0000);
    endtask

    task automatic t_periph();
        wr(3'd3, 32'hFFFF_FFFF);
        periph_req = 20'h00001;
        #1;
        chk("R7 request 0 on vector 12", pend_vec, 32'h0000_1000);
        periph_req = 20'h80000;
        #1;
        chk("R7 request 19 on vector 31, request 0 dropped", pend_vec, 32'h8000_0000);
        periph_req = 20'h0;
        #1;
        chk("R7 no latching", {31'h0, irq}, 32'h0);
        @(negedge clk);
        wr(3'd3, 32'hFFFF_EFFF);
        periph_req = 20'h00001;
        #1;
        chk("R8 masked request 0", {31'h0, irq}, 32'h0);
        periph_req = 20'h0;
        @(negedge clk);
    endtask

    task automatic t_multi_map();
        logic [31:0] v;
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_0401);
        pins(32'h0000_0401);
        periph_req = 20'h00004;
        #1;
        chk("R10 all pending vectors shown", pend_vec, 32'h0000_4401);
        rd(3'd4, v);
        chk("R9 pending register readback", v, 32'h0000_4401);
        @(negedge clk);
        wr(3'd4, 32'h0000_0000);
        rd(3'd3, v);
        chk("R9 write to pending register ignored", v, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R9 pending unchanged after write", v, 32'h0000_4401);
        rd(3'd7, v);
        chk("R9 unused address reads zero", v, 32'h0);
        periph_req = 20'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        do_reset(); t_latency();
        do_reset(); t_modes();
        do_reset(); t_w1c();
        do_reset(); t_collide();
        do_reset(); t_lump();
        do_reset(); t_periph();
        do_reset(); t_multi_map();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule